// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Unit

This block gathers the interrupt causes of a single card socket and turns them into one interrupt line for the host. It watches six socket pins: the card interrupt request, the status-change line, card detect, ready, battery warning and battery dead. Each pin passes through a synchronizer. A cause is then latched in a status register, and the host can mask each cause through an 8-bit enable register. Both registers sit on a one-bit-address register bus. Writes take effect at the clock edge, and reads are combinational.

A two-bit mode field in the enable register sets how the interrupt-request pin is treated: ignored, active-low level, falling edge or rising edge. A separate enable bit turns each card-detect change into a one-cycle reset pulse for the socket's general and software control registers, which sit outside this block. A power-up reset clears everything. A software reset clears only the latched status flags and leaves the enable register as it was.

Enable register (address 0): bit 7 change-reset enable, bits 6:5 request mode (00 off, 01 level, 10 falling edge, 11 rising edge), bit 4 status-change enable, bit 3 card-detect enable, bit 2 ready enable, bit 1 battery-warning enable, bit 0 battery-dead enable. Status register (address 1): bits 7:6 read 0, bit 5 request, bit 4 status change, bit 3 card detect, bit 2 ready, bit 1 battery warning, bit 0 battery dead.

Top module: `csc_irq_unit`

## Requirements
- R1: While por_n is low, the enable register reads 0x00, status bits 4:0 read 0, and irq and ctl_rst are 0.
- R2: All eight enable-register bits can be written and read back. A soft_rst pulse leaves the enable register unchanged.
- R3: In request mode 00, status bit 5 is a read-only live copy of the inverted, synchronized request pin, writing 1 to it has no effect, and the request pin never asserts irq.
- R4: In request mode 01, status bit 5 and irq are 1 from two cycles after the request pin goes low until it goes high again. Writing 1 to bit 5 does not clear it while the pin is low.
- R5: In request mode 10, a 1-to-0 change of the request pin sets status bit 5, which stays set until cleared. A 0-to-1 change does not set it.
- R6: In request mode 11, a 0-to-1 change of the request pin sets status bit 5, which stays set until cleared. A 1-to-0 change does not set it.
- R7: A 1-to-0 change of the status-change pin sets status bit 4 whether or not enable bit 4 is set. A 0-to-1 change does not set it. Bit 4 drives irq only when enable bit 4 is 1.
- R8: Any change of card detect, ready, battery warning or battery dead sets status bit 3, 2, 1 or 0 respectively. The bit becomes readable on the third rising clock edge after the pin changes.
- R9: When enable bit 7 is 1, ctl_rst is high for one cycle, in the same cycle that the card-detect status bit becomes set. When bit 7 is 0, a card-detect change leaves ctl_rst at 0.
- R10: irq is the OR over status bits 4:0 each ANDed with the enable bit of the same position, plus bit 5 when the mode is not 00. Clearing an enable bit removes its cause from irq right after the write edge.
- R11: Writing the status address clears each latched bit whose data bit is 1 and leaves bits written with 0. If a set event and a clear land on the same edge, the bit stays set.
- R12: A soft_rst cycle clears status bits 4:0 and any edge-latched bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, synchronous, clears status flags only |
| bus_addr | input | 1 | Register select: 0 enable, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_ireq | input | 1 | Card interrupt request pin |
| pin_stschg | input | 1 | Card status-change pin |
| pin_cd | input | 1 | Card detect pin, high when a card is present |
| pin_rdy | input | 1 | Card ready pin |
| pin_bwarn | input | 1 | Battery warning pin |
| pin_bdead | input | 1 | Battery dead pin |
| irq | output | 1 | Combined interrupt request |
| ctl_rst | output | 1 | One-cycle reset for the socket control registers |

## Verification
The bench targets three kinds of mistake. The first is getting the edge polarity of the two edge modes and of the status-change pin wrong; a swapped design latches on the release rather than the assertion. The second is the level mode: a design that lets a write-one-to-clear take hold of a level request would drop irq while the card still holds the pin low. The third is the collision of an edge event and a clear on the same edge: losing the event there would hide an interrupt. The bench also checks the exact cycle of the change-reset pulse, its gating by bit 7, and that software reset spares the enable register, because a design that cleared it would silently mask every cause.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int REG_W = 8;
  localparam int STS_W = 6;

  // Status / pin vector positions (enable bits share the low positions).
  localparam int STS_BDEAD = 0;
  localparam int STS_BWARN = 1;
  localparam int STS_RDY   = 2;
  localparam int STS_CD    = 3;
  localparam int STS_CHG   = 4;
  localparam int STS_IREQ  = 5;
  localparam int EN_CHGRST = 7;

  localparam logic ADDR_EN  = 1'b0;
  localparam logic ADDR_STS = 1'b1;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'b00,
    IRQ_LEVEL = 2'b01,
    IRQ_FALL  = 2'b10,
    IRQ_RISE  = 2'b11
  } irq_mode_e;

  typedef struct packed {
    logic      chg_rst;
    irq_mode_e mode;
    logic      chg_en;
    logic      cd_en;
    logic      rdy_en;
    logic      bwarn_en;
    logic      bdead_en;
  } en_reg_t;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int          N      = 6,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/csc_delay.sv
module csc_delay #(
  parameter int           N    = 6,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // One-cycle-old copy of the synchronized pins, used for edge finding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= d;
  end
endmodule

// File: rtl/csc_en_reg.sv
module csc_en_reg
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output en_reg_t          q
);
  // Cleared by power-up reset only; soft reset is deliberately not an input.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  q <= '0;
    else if (wr) q <= en_reg_t'(wdata);
  end
endmodule

// File: rtl/csc_status.sv
module csc_status
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  irq_mode_e        mode,
  input  logic [STS_W-1:0] cur,
  input  logic [STS_W-1:0] prev,
  input  logic             clr_stb,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts
);
  logic [STS_CHG-1:0] any_edge;
  logic [STS_CHG:0]   set_ev;
  logic [STS_CHG:0]   sticky;
  logic               ireq_set;
  logic               pulse_mode;
  logic               ireq_lat;

  assign any_edge          = cur[STS_CHG-1:0] ^ prev[STS_CHG-1:0];
  assign set_ev[STS_CHG-1:0] = any_edge;
  assign set_ev[STS_CHG]   = prev[STS_CHG] & ~cur[STS_CHG];

  // Sticky flags for causes 4..0: event beats clear, soft reset beats both.
  for (genvar b = 0; b <= STS_CHG; b++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                       q <= 1'b0;
      else if (soft_rst)                q <= 1'b0;
      else if (set_ev[b])               q <= 1'b1;
      else if (clr_stb && clr_mask[b])  q <= 1'b0;
    end
    assign sticky[b] = q;
  end

  assign pulse_mode = (mode == IRQ_FALL) || (mode == IRQ_RISE);

  always_comb begin
    unique case (mode)
      IRQ_FALL: ireq_set = prev[STS_IREQ] & ~cur[STS_IREQ];
      IRQ_RISE: ireq_set = ~prev[STS_IREQ] & cur[STS_IREQ];
      default:  ireq_set = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          ireq_lat <= 1'b0;
    else if (soft_rst || !pulse_mode)    ireq_lat <= 1'b0;
    else if (ireq_set)                   ireq_lat <= 1'b1;
    else if (clr_stb && clr_mask[STS_IREQ]) ireq_lat <= 1'b0;
  end

  // Off and level modes show the live inverted pin; edge modes show the latch.
  assign sts[STS_IREQ]  = pulse_mode ? ireq_lat : ~cur[STS_IREQ];
  assign sts[STS_CHG:0] = sticky;
endmodule

// File: rtl/csc_irq_unit.sv
module csc_irq_unit
  import csc_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [STS_W-1:0] PIN_IDLE    = 6'b110111
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             pin_ireq,
  input  logic             pin_stschg,
  input  logic             pin_cd,
  input  logic             pin_rdy,
  input  logic             pin_bwarn,
  input  logic             pin_bdead,
  output logic             irq,
  output logic             ctl_rst
);
  localparam int PAD_W = REG_W - STS_W;

  logic [STS_W-1:0] pin_vec;
  logic [STS_W-1:0] pin_s;
  logic [STS_W-1:0] pin_p;
  en_reg_t          en_q;
  logic [REG_W-1:0] en_bits;
  logic [STS_W-1:0] sts_bits;
  logic [STS_W-1:0] cause_en;
  logic             cd_edge;
  logic             ctl_rst_q;

  assign pin_vec = {pin_ireq, pin_stschg, pin_cd, pin_rdy, pin_bwarn, pin_bdead};

  csc_sync #(.N(STS_W), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(por_n), .d(pin_vec), .q(pin_s)
  );

  csc_delay #(.N(STS_W), .INIT(PIN_IDLE)) u_prev (
    .clk(clk), .rst_n(por_n), .d(pin_s), .q(pin_p)
  );

  csc_en_reg u_en (
    .clk(clk), .por_n(por_n),
    .wr(bus_wr && (bus_addr == ADDR_EN)),
    .wdata(bus_wdata), .q(en_q)
  );

  csc_status u_sts (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .mode(en_q.mode),
    .cur(pin_s), .prev(pin_p),
    .clr_stb(bus_wr && (bus_addr == ADDR_STS)),
    .clr_mask(bus_wdata[STS_W-1:0]),
    .sts(sts_bits)
  );

  assign en_bits  = en_q;
  assign cause_en = {en_q.mode != IRQ_OFF, en_bits[STS_CHG:0]};
  assign irq      = |(sts_bits & cause_en);

  assign cd_edge = pin_s[STS_CD] ^ pin_p[STS_CD];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctl_rst_q <= 1'b0;
    else        ctl_rst_q <= en_q.chg_rst & cd_edge;
  end
  assign ctl_rst = ctl_rst_q;

  always_comb begin
    if (bus_addr == ADDR_EN) bus_rdata = en_bits;
    else                     bus_rdata = {{PAD_W{1'b0}}, sts_bits};
  end
endmodule

// File: rtl/csc_irq_unit_chk.sv
module csc_irq_unit_chk (
  input logic       clk,
  input logic       por_n,
  input logic       soft_rst,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] en_q,
  input logic [5:0] sts_q,
  input logic       irq,
  input logic       ctl_rst
);
  // R1: reset state
  always @(posedge clk) begin
    if (!por_n) begin
      a_r1_reset_clean: assert (en_q == 8'h00 && sts_q[4:0] == 5'd0 && !ctl_rst && !irq);
    end
  end

  // R2: soft reset without an enable write keeps the enable register
  a_r2_soft_keeps_enable: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst && !(bus_wr && !bus_addr)) |=> $stable(en_q));

  // R3: off mode with no low enables gives no interrupt
  a_r3_off_mode_silent: assert property (@(posedge clk) disable iff (!por_n)
    (en_q[6:5] == 2'b00 && en_q[4:0] == 5'd0) |-> !irq);

  // R4: level mode with the request active forces irq
  a_r4_level_drives_irq: assert property (@(posedge clk) disable iff (!por_n)
    (en_q[6:5] == 2'b01 && sts_q[5]) |-> irq);

  // R9: change-reset pulse only when bit 7 was set
  a_r9_pulse_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
    ctl_rst |-> $past(en_q[7]));

  // R12: soft reset wipes sticky flags on the next cycle
  a_r12_soft_clears_flags: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (sts_q[4:0] == 5'd0));
endmodule

bind csc_irq_unit csc_irq_unit_chk u_chk (
  .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .en_q(en_bits), .sts_q(sts_bits),
  .irq(irq), .ctl_rst(ctl_rst)
);

// File: tb/csc_irq_unit_test.sv
module csc_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] IDLE = 6'b110111;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [5:0] pins = IDLE;   // [5]ireq [4]stschg [3]cd [2]rdy [1]bwarn [0]bdead
  logic       irq, ctl_rst;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_irq_unit uut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_ireq(pins[5]), .pin_stschg(pins[4]), .pin_cd(pins[3]),
    .pin_rdy(pins[2]), .pin_bwarn(pins[1]), .pin_bdead(pins[0]),
    .irq(irq), .ctl_rst(ctl_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic soft_pulse();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [5:0] st, input logic [7:0] en);
    return |(st & {en[6:5] != 2'b00, en[4:0]});
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic [7:0] en;
    logic [5:0] est;
    void'($urandom(32'd20240611));
    cyc(3);
    chk("R1 irq in reset", irq, 0);
    chk("R1 ctl_rst in reset", ctl_rst, 0);
    rd(0, r); chk("R1 enable in reset", r, 8'h00);
    por_n = 1'b1;
    cyc(1);
    rd(1, r); chk("R1 status after reset", r, 8'h00);

    // R2 enable read/write, soft reset keeps it
    for (int i = 0; i < 8; i++) begin
      en = 8'($urandom);
      wr(0, en);
      rd(0, r); chk("R2 enable readback", r, en);
    end
    wr(0, 8'hA5); soft_pulse();
    rd(0, r); chk("R2 enable after soft_rst", r, 8'hA5);
    wr(0, 8'h00);

    // R3 off mode: live inverted pin, read-only, no irq
    pins[5] = 1'b0; cyc(2);
    rd(1, r); chk("R3 live bit5 low pin", r[5], 1);
    chk("R3 no irq in off mode", irq, 0);
    wr(1, 8'h20);
    rd(1, r); chk("R3 bit5 ignores clear", r[5], 1);
    pins[5] = 1'b1; cyc(2);
    rd(1, r); chk("R3 live bit5 high pin", r[5], 0);

    // R4 level mode
    wr(0, 8'h20);
    pins[5] = 1'b0; cyc(1);
    chk("R4 irq not yet (sync)", irq, 0);
    cyc(1);
    chk("R4 irq while low", irq, 1);
    wr(1, 8'h20);
    rd(1, r); chk("R4 clear ignored while low", r[5], 1);
    chk("R4 irq held while low", irq, 1);
    pins[5] = 1'b1; cyc(2);
    chk("R4 irq drops with pin", irq, 0);

    // R10 clearing an enable drops irq right after the write
    pins[5] = 1'b0; cyc(2);
    chk("R10 irq before disable", irq, 1);
    wr(0, 8'h00);
    chk("R10 irq after disable", irq, 0);
    pins[5] = 1'b1; cyc(2);

    // R5 falling-edge mode
    wr(0, 8'h40);
    pins[5] = 1'b0; cyc(3);
    rd(1, r); chk("R5 fall sets bit5", r[5], 1);
    chk("R5 irq on fall", irq, 1);
    wr(1, 8'h20);
    rd(1, r); chk("R5 clear bit5", r[5], 0);
    pins[5] = 1'b1; cyc(3);
    rd(1, r); chk("R5 rise ignored", r[5], 0);
    chk("R5 irq quiet", irq, 0);

    // R6 rising-edge mode
    wr(0, 8'h60);
    pins[5] = 1'b0; cyc(3);
    rd(1, r); chk("R6 fall ignored", r[5], 0);
    pins[5] = 1'b1; cyc(3);
    rd(1, r); chk("R6 rise sets bit5", r[5], 1);
    chk("R6 irq on rise", irq, 1);
    wr(1, 8'h20);
    rd(1, r); chk("R6 clear bit5", r[5], 0);
    wr(0, 8'h00);

    // R7 status-change pin
    pins[4] = 1'b0; cyc(3);
    rd(1, r); chk("R7 fall sets bit4", r[4], 1);
    chk("R7 no irq while disabled", irq, 0);
    wr(0, 8'h10);
    chk("R7 irq when enabled", irq, 1);
    wr(1, 8'h10);
    rd(1, r); chk("R7 cleared", r[4], 0);
    pins[4] = 1'b1; cyc(3);
    rd(1, r); chk("R7 rise ignored", r[4], 0);
    wr(0, 8'h00);

    // R9 change-reset pulse timing and gating
    wr(0, 8'h80);
    pins[3] = 1'b1; cyc(2);
    chk("R9 no pulse before flag", ctl_rst, 0);
    cyc(1);
    chk("R9 pulse with flag", ctl_rst, 1);
    rd(1, r); chk("R8 cd flag set", r[3], 1);
    cyc(1);
    chk("R9 pulse one cycle", ctl_rst, 0);
    wr(0, 8'h00);
    pins[3] = 1'b0; cyc(3);
    chk("R9 no pulse when disabled", ctl_rst, 0);
    wr(1, 8'h08);

    // R11 set beats clear on the same edge; zero bits untouched
    pins[2] = 1'b0; cyc(2);
    wr(1, 8'h04);
    rd(1, r); chk("R11 set wins over clear", r[2], 1);
    wr(1, 8'h00);
    rd(1, r); chk("R11 zero write keeps", r[2], 1);
    wr(1, 8'h04);
    rd(1, r); chk("R11 clear", r[2], 0);

    // R12 soft reset clears flags, keeps enables
    wr(0, 8'h0F);
    pins[1] = 1'b0; pins[0] = 1'b0; cyc(3);
    rd(1, r); chk("R8 battery flags set", r[1:0], 2'b11);
    soft_pulse();
    rd(1, r); chk("R12 flags cleared", r[4:0], 0);
    rd(0, r); chk("R12 enable kept", r, 8'h0F);
    chk("R12 irq cleared", irq, 0);

    // Random: edges on sticky pins, random enables and clear masks (R8, R10, R11)
    wr(1, 8'h3F);
    est = 6'd0;
    for (int i = 0; i < 40; i++) begin
      int idx;
      logic [7:0] m;
      en = 8'($urandom) & 8'h9F;
      wr(0, en);
      idx = int'($urandom % 5);
      pins[idx] = ~pins[idx];
      cyc(3);
      if (idx != 4 || pins[4] == 1'b0) est[idx] = 1'b1;
      chk("R9 random pulse", ctl_rst, (idx == 3) ? en[7] : 1'b0);
      rd(1, r); chk("R8 random status", r, {2'b00, est});
      chk("R10 random irq", irq, exp_irq(est, en));
      m = 8'($urandom);
      wr(1, m);
      est = est & ~m[5:0] & 6'h1F;
      rd(1, r); chk("R11 random clear", r, {2'b00, est});
      chk("R10 irq after clear", irq, exp_irq(est, en));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule